// File: doc/BRIEF.md
# Fully Associative Write-Through Cache

This block sits between a processor request port and a slow external memory port and keeps a small set of recently read words close to the processor. Every entry stores the whole memory address beside its data word, so any address can live in any entry and a lookup compares the request against all entries at once. A read that matches a valid entry returns the stored word one cycle after the request is taken, and the external memory sees nothing. A read that misses starts a memory read. The returned word goes back to the processor and is written into an entry together with its address.

Writes always go to external memory. When the written address is already cached, the stored word is replaced at the same edge that the memory acknowledges the write. A write to an address that is not cached does not take an entry. When a new word has to be placed and no entry is free, the entry that has been read the fewest times is overwritten. Each entry counts its read hits in a small saturating counter.

The processor raises `req` with `we`, `addr` and `wdata` and keeps them unchanged until it sees `ready` high. In that same cycle it drops `req` or presents its next request. Only one request is handled at a time. The memory may take any number of cycles before it raises `memAck` for one cycle.

Top module: `assoc_cache`

## Requirements
- R1: After reset, `ready` and `memReq` are low and no entry is valid, so the first read of any address after reset is a miss.
- R2: On a read miss, `memReq` goes high with `memWe`=0 and `memAddr` equal to the request address. All three stay stable until `memAck`. `ready` is then high for exactly one cycle, the cycle after `memAck`, with `rdata` equal to the `memRdata` captured at `memAck`.
- R3: On a read hit, `ready` is high in the cycle after the request is taken, `memReq` stays low for the whole request, and `rdata` is the stored word.
- R4: The tag is the complete 16-bit address. Two addresses that differ only in bit 15 can both be cached at the same time, and both hit.
- R5: Every write raises `memReq` with `memWe`=1, `memAddr`=`addr` and `memWdata`=`wdata`, whether or not it hits. `ready` follows in the cycle after `memAck`.
- R6: A write to a cached address replaces the stored word at the `memAck` edge. The next read of that address hits and returns the written word. The entry's use count is not changed by the write.
- R7: A write to an address that is not cached takes no entry. The next read of that address misses.
- R8: The word fetched by a read miss goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry with the lowest use count, and a tie goes to the lowest-numbered entry.
- R9: A newly filled entry has use count 1. Each read hit adds 1 to the entry it hit. The count saturates at 15 (2^CNTW−1 with the default CNTW=4) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Processor request, held until `ready` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Request address |
| wdata | input | 32 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid while `ready` is high after a read |
| memReq | output | 1 | External memory request, held until `memAck` |
| memWe | output | 1 | External access is a write |
| memAddr | output | 16 | External memory address |
| memWdata | output | 32 | External write data |
| memAck | input | 1 | One-cycle completion from external memory |
| memRdata | input | 32 | External read data, valid with `memAck` |

## Verification
Two pairs of actions share a clock edge. On a write hit, the external write completing and the stored word being replaced happen at the same edge. The bench writes a cached address and reads it back straight after `ready`, and expects a hit carrying the new word with no memory cycle. On a read miss with every entry full, choosing the victim and filling it also happen at one edge. This is provoked by shaping the use counts so that eviction by lowest count, the lowest-index tie-break and counter saturation each decide which address survives. Each case is judged only by hit or miss at the ports: a hit shows as `ready` one cycle after the request with no memory request, a miss shows as a memory request.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_DONE = 2'd2
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // capture request fields and hit vector
    logic bump;       // read hit: advance use count of matching entry
    logic fill;       // read miss completed: write victim entry
    logic wrUpd;      // write completed: refresh matching entry
    logic loadRdata;  // read miss completed: memory word to rdata
  } ctrlStrobes_t;

endpackage

// File: rtl/assoc_cache_dp.sv
module assoc_cache_dp
  import assoc_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int CNTW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] memRdata,
  output logic          hit,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] wdataQ
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};
  localparam logic [CNTW-1:0] CONE = CNTW'(1);

  logic [ENTRIES-1:0] matchNow;
  logic [ENTRIES-1:0] matchQ;
  logic [ENTRIES-1:0] validArr;
  logic [ENTRIES-1:0] victimOh;
  logic [DW-1:0]      dataArr [ENTRIES];
  logic [CNTW-1:0]    cntArr  [ENTRIES];
  logic [DW-1:0]      hitData;
  logic [IW-1:0]      victimIdx;

  // one storage slot per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [AW-1:0]   tagR;
    logic [DW-1:0]   dataR;
    logic            validR;
    logic [CNTW-1:0] cntR;

    assign matchNow[g] = validR && (tagR == addr);
    assign validArr[g] = validR;
    assign dataArr[g]  = dataR;
    assign cntArr[g]   = cntR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagR   <= '0;
        dataR  <= '0;
        validR <= 1'b0;
        cntR   <= '0;
      end else if (strb.fill && victimOh[g]) begin
        tagR   <= addrQ;
        dataR  <= memRdata;
        validR <= 1'b1;
        cntR   <= CONE;
      end else if (strb.wrUpd && matchQ[g]) begin
        dataR  <= wdataQ;
      end else if (strb.bump && matchNow[g] && (cntR != CMAX)) begin
        cntR   <= cntR + CONE;
      end
    end
  end

  assign hit = |matchNow;

  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitData = hitData | ({DW{matchNow[i]}} & dataArr[i]);
    end
  end

  // victim: lowest invalid slot, else lowest count, ties to lowest index
  always_comb begin
    logic            found;
    logic [CNTW-1:0] best;
    found     = 1'b0;
    victimIdx = '0;
    best      = cntArr[0];
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !validArr[i]) begin
        found     = 1'b1;
        victimIdx = IW'(i);
      end
    end
    if (!found) begin
      for (int i = 1; i < ENTRIES; i++) begin
        if (cntArr[i] < best) begin
          best      = cntArr[i];
          victimIdx = IW'(i);
        end
      end
    end
  end

  always_comb begin
    victimOh = '0;
    victimOh[victimIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      matchQ <= '0;
      rdata  <= '0;
    end else begin
      if (strb.accept) begin
        addrQ  <= addr;
        wdataQ <= wdata;
        matchQ <= matchNow;
      end
      if (strb.bump) begin
        rdata <= hitData;
      end else if (strb.loadRdata) begin
        rdata <= memRdata;
      end
    end
  end

endmodule

// File: rtl/assoc_cache_ctrl.sv
module assoc_cache_ctrl
  import assoc_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         req,
  input  logic         we,
  input  logic         hit,
  input  logic         memAck,
  output ctrlStrobes_t strb,
  output logic         ready,
  output logic         memReq,
  output logic         memWe
);

  cacheState_t state;
  cacheState_t stateNext;
  logic        weQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          strb.accept = 1'b1;
          if (!we && hit) begin
            strb.bump = 1'b1;
            stateNext = ST_DONE;
          end else begin
            stateNext = ST_MEM;
          end
        end
      end
      ST_MEM: begin
        if (memAck) begin
          strb.wrUpd     = weQ;
          strb.fill      = !weQ;
          strb.loadRdata = !weQ;
          stateNext      = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      weQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.accept) weQ <= we;
    end
  end

  assign ready  = (state == ST_DONE);
  assign memReq = (state == ST_MEM);
  assign memWe  = weQ;

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import assoc_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int CNTW    = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata
);

  ctrlStrobes_t strb;
  logic         hitNow;

  assoc_cache_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .we     (we),
    .hit    (hitNow),
    .memAck (memAck),
    .strb   (strb),
    .ready  (ready),
    .memReq (memReq),
    .memWe  (memWe)
  );

  assoc_cache_dp #(
    .ENTRIES (ENTRIES),
    .AW      (AW),
    .DW      (DW),
    .CNTW    (CNTW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .wdata    (wdata),
    .memRdata (memRdata),
    .hit      (hitNow),
    .rdata    (rdata),
    .addrQ    (memAddr),
    .wdataQ   (memWdata)
  );

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk
  import assoc_cache_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          req,
  input logic          we,
  input logic          ready,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          memAck,
  input ctrlStrobes_t  strb,
  input logic          hit
);

  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R2
  mem_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq && ready);

  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept && req && !we && hit |=> ready && !memReq);

  // R5
  wr_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && we |-> $past(memAck) && memWe);

  // R7
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> !we && memAck && !memWe);

  // R6
  wr_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrUpd |-> we && memAck && memReq);

endmodule

bind assoc_cache assoc_cache_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .req      (req),
  .we       (we),
  .ready    (ready),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memAck   (memAck),
  .strb     (strb),
  .hit      (hitNow)
);

// File: tb/assoc_cache_tb.sv
`timescale 1ns/1ps
module assoc_cache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        memReq;
  logic        memWe;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int memLat = 0;
  int waitCnt = 0;
  logic        memSeen = 1'b0;
  logic        memWeSeen = 1'b0;
  logic [15:0] memAddrSeen = '0;
  logic [31:0] memWdataSeen = '0;

  always #2 clk = ~clk;

  assoc_cache u_dut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] memWord(input logic [15:0] a);
    return {a ^ 16'hC35A, ~a};
  endfunction

  // external memory model with programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
      end else if (memReq) begin
        if (!memSeen) begin
          memSeen = 1'b1;
          memWeSeen = memWe;
          memAddrSeen = memAddr;
          memWdataSeen = memWdata;
        end
        if (waitCnt >= memLat) begin
          memAck = 1'b1;
          memRdata = memWord(memAddr);
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic opWe, input logic [15:0] opAddr, input logic [31:0] opWdata,
                      output logic wasHit, output logic [31:0] gotData);
    int cyc;
    @(negedge clk);
    req = 1'b1; we = opWe; addr = opAddr; wdata = opWdata;
    memSeen = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready && cyc < 100);
    if (!ready) check(1'b0, "R2 request timeout", 32'(cyc), 32'd100);
    gotData = rdata;
    wasHit = (cyc == 1) && !memSeen;
    req = 1'b0;
  endtask

  task automatic readExpect(input logic [15:0] a, input logic expHit, input string tag);
    logic h;
    logic [31:0] d;
    doOp(1'b0, a, 32'h0, h, d);
    check(h == expHit, tag, 32'(h), 32'(expHit));
    check(d == memWord(a), tag, d, memWord(a));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1 outputs quiet in reset
    check(!ready && !memReq, "R1 reset outputs", {30'd0, ready, memReq}, 32'd0);
    rstN = 1'b1;
  endtask

  // {we, addr, wdata, expHit, expect wdata field as read data}
  localparam int NV = 13;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 16'h1234, 32'h0000_0000, 1'b0, 1'b0},  // R1 first read misses
    {1'b0, 16'h1234, 32'h0000_0000, 1'b1, 1'b0},  // R3 filled word hits
    {1'b0, 16'h9234, 32'h0000_0000, 1'b0, 1'b0},  // R4 differs in bit 15
    {1'b0, 16'h1234, 32'h0000_0000, 1'b1, 1'b0},  // R4
    {1'b0, 16'h9234, 32'h0000_0000, 1'b1, 1'b0},  // R4
    {1'b1, 16'h1234, 32'hDEAD_BEEF, 1'b0, 1'b0},  // R5 write hit to memory
    {1'b0, 16'h1234, 32'hDEAD_BEEF, 1'b1, 1'b1},  // R6 new word returned
    {1'b1, 16'h0777, 32'h0102_0304, 1'b0, 1'b0},  // R5 write miss
    {1'b0, 16'h0777, 32'h0000_0000, 1'b0, 1'b0},  // R7 not allocated
    {1'b0, 16'h0777, 32'h0000_0000, 1'b1, 1'b0},  // R2 miss filled
    {1'b0, 16'hFFFF, 32'h0000_0000, 1'b0, 1'b0},  // R2
    {1'b0, 16'h0000, 32'h0000_0000, 1'b0, 1'b0},  // R2
    {1'b0, 16'hFFFF, 32'h0000_0000, 1'b1, 1'b0}   // R3
  };

  initial begin
    logic h;
    logic [31:0] d;
    doReset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic        vWe;
      logic [15:0] vAddr;
      logic [31:0] vData;
      logic        vHit;
      logic        vFromW;
      {vWe, vAddr, vData, vHit, vFromW} = VEC[i];
      memLat = i % 4;
      doOp(vWe, vAddr, vData, h, d);
      if (vWe) begin
        check(memSeen && memWeSeen, "R5 write reaches memory", {30'd0, memSeen, memWeSeen}, 32'd3);
        check(memAddrSeen == vAddr && memWdataSeen == vData, "R5 write address and data",
              memWdataSeen, vData);
      end else begin
        check(h == vHit, "R1/R3 hit status", 32'(h), 32'(vHit));
        if (!vHit) check(memSeen && !memWeSeen && memAddrSeen == vAddr, "R2 miss request",
                         {16'd0, memAddrSeen}, {16'd0, vAddr});
        check(d == (vFromW ? vData : memWord(vAddr)), "R2/R3/R6 read data", d,
              vFromW ? vData : memWord(vAddr));
      end
    end

    // R8 tie: all counts equal, lowest entry goes
    memLat = 1;
    doReset();
    for (int k = 0; k < 8; k++) readExpect(16'h0100 + 16'(k), 1'b0, "R8 fill free entries");
    for (int k = 0; k < 8; k++) readExpect(16'h0100 + 16'(k), 1'b1, "R8 all eight held");
    readExpect(16'h0200, 1'b0, "R8 new address misses");
    for (int k = 1; k < 8; k++) readExpect(16'h0100 + 16'(k), 1'b1, "R8 survivors hit");
    readExpect(16'h0100, 1'b0, "R8 tie evicts entry 0");

    // R8 lowest count evicted
    doReset();
    for (int k = 0; k < 8; k++) readExpect(16'h0300 + 16'(k), 1'b0, "R8 fill");
    for (int k = 0; k < 8; k++) if (k != 5) readExpect(16'h0300 + 16'(k), 1'b1, "R8 raise counts");
    readExpect(16'h0400, 1'b0, "R8 new address");
    readExpect(16'h0305, 1'b0, "R8 least used evicted");
    readExpect(16'h0300, 1'b1, "R8 used entry kept");

    // R9 saturation: entry 1 gets 20 hits, all others 14
    doReset();
    for (int k = 0; k < 8; k++) readExpect(16'h0500 + 16'(k), 1'b0, "R9 fill");
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n < ((k == 1) ? 20 : 14); n++) begin
        readExpect(16'h0500 + 16'(k), 1'b1, "R9 repeated hits");
      end
    end
    readExpect(16'h0600, 1'b0, "R9 new address");
    readExpect(16'h0501, 1'b1, "R9 saturated count kept entry 1");
    readExpect(16'h0500, 1'b0, "R9 all tied at max, entry 0 evicted");

    // R6 write hit then immediate read, memory slow
    memLat = 3;
    doOp(1'b1, 16'h0503, 32'hCAFE_F00D, h, d);
    check(memSeen && memWeSeen, "R5 write hit still goes to memory", {31'd0, memSeen}, 32'd1);
    doOp(1'b0, 16'h0503, 32'h0, h, d);
    check(h, "R6 read after write hit", 32'(h), 32'd1);
    check(d == 32'hCAFE_F00D, "R6 updated word", d, 32'hCAFE_F00D);

    // R1 reset clears contents
    doReset();
    readExpect(16'h0501, 1'b0, "R1 reset invalidates");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule